// File: doc/BRIEF.md
# Pin Transition Interrupt Controller

This block watches sixteen external request lines and turns selected level transitions on them into latched interrupt requests. Each line passes through a two-flop synchronizer, and its synchronized level is compared with the value from the previous cycle. A per-line mode bit chooses whether any change of level or only a high-to-low transition records a request. Recorded requests are held in a pending register until software clears them. The pending register is gated by a mask register, and a fixed-priority resolver reports the winning line as a 6-bit vector code together with an interrupt line.

Software reaches the block through a small register port. The port has a 2-bit address, a write strobe, write data and combinational read data. Address 0 holds the edge-mode register, address 1 holds the mask register and address 2 holds the pending register. Writing ones to address 2 clears the matching pending bits. When no unmasked request is waiting, the vector output carries an error code instead of a line code, so an interrupt handler always reads a defined value.

Top module: `ext_pin_irq_ctrl`

## Requirements
- R1: Each of the 16 lines `pin_i[i]` owns pending bit i, which reads back as bit i of `reg_rd_data` at address 2.
- R2: With mode bit i = 0, both rising and falling transitions of line i set pending bit i. With mode bit i = 1, only a falling transition sets it, and a rising transition is ignored.
- R3: A masked line (mask bit i = 0) keeps its pending bit set but does not raise `irq_o` or win the vector.
- R4: After reset, the mode, mask and pending registers are all zero, `irq_o` is 0 and `vector_o` carries the error code.
- R5: `vector_o` equals {2'b11, 15 - i}, where i is the highest-indexed line whose pending and mask bits are both set. Line 15 has the highest priority and line 0 the lowest.
- R6: When no line is both pending and unmasked, `vector_o` is 6'b00_0000.
- R7: A transition on `pin_i` is reflected in the pending register after the third rising clock edge following the change, and not after the second.
- R8: Writing to address 2 clears exactly the pending bits written as 1. Bits written as 0 are unchanged, and a write to address 2 never sets a bit.
- R9: If a transition is detected on a line in the same cycle that software clears its pending bit, the bit ends up set.
- R10: `irq_o` is 1 exactly when the bitwise AND of pending and mask is nonzero.
- R11: The mode register (address 0) and mask register (address 1) read back the last value written, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 16 | Asynchronous external request lines |
| reg_addr | input | 2 | Register select (0 mode, 1 mask, 2 pending, 3 unused) |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 16 | Write data; at address 2, ones clear pending bits |
| reg_rd_data | output | 16 | Combinational read data of the selected register |
| irq_o | output | 1 | Interrupt request, high while any unmasked line is pending |
| vector_o | output | 6 | Code of the winning line, or the error code |

## Verification
A wrong synchronizer depth or a wrong edge detector shows up as a pending bit that appears one cycle early, one cycle late, or on the wrong transition polarity. Reading the pending register on the second and third cycle after each transition catches these faults, for every line and both modes. A corrupted mask or pending bit, or a resolver with the wrong priority order, changes `vector_o` and `irq_o` in the same cycle, because both are combinational from the registers. Comparing the vector against the bench's own highest-bit search, over a spread of pending and mask patterns, therefore exposes such faults immediately. An error in the clear logic shows up on the next read of address 2.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int NUM_LINES   = 16;
    localparam int IDX_W       = $clog2(NUM_LINES);
    localparam int VEC_W       = 6;
    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;

    localparam logic [VEC_W-1:0]       ERR_VEC  = '0;
    localparam logic [VEC_W-IDX_W-1:0] VEC_BASE = '1;

    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MODE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PEND = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } winner_t;

    // Line index to vector code: the highest index gets the lowest code.
    function automatic logic [VEC_W-1:0] code_of(input logic [IDX_W-1:0] idx);
        return {VEC_BASE, IDX_W'(IDX_W'(NUM_LINES - 1) - idx)};
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync
    import pin_irq_pkg::*;
#(
    parameter int W      = NUM_LINES,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/edge_detect.sv
module edge_detect
    import pin_irq_pkg::*;
#(
    parameter int W = NUM_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] fall_only_i,
    output logic [W-1:0] hit_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_i;
    end

    for (genvar g = 0; g < W; g++) begin : g_lane
        assign hit_o[g] = fall_only_i[g] ? (prev_q[g] & ~level_i[g])
                                         : (prev_q[g] ^ level_i[g]);
    end

    // R2: a lane in falling-only mode never reports a hit while its level is high
    fall_mode_chk: assert property (@(posedge clk) disable iff (rst)
        ((hit_o & fall_only_i & level_i) == '0));

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import pin_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  line_vec_t         wr_data_i,
    input  line_vec_t         hit_i,
    output line_vec_t         mode_o,
    output line_vec_t         mask_o,
    output line_vec_t         pend_o,
    output line_vec_t         rd_data_o
);

    line_vec_t mode_q, mask_q, pend_q;
    line_vec_t clr;
    reg_sel_e  sel;

    assign sel = reg_sel_e'(addr_i);
    assign clr = (wr_en_i && sel == SEL_PEND) ? wr_data_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            if (wr_en_i && sel == SEL_MODE) mode_q <= wr_data_i;
            if (wr_en_i && sel == SEL_MASK) mask_q <= wr_data_i;
            pend_q <= (pend_q & ~clr) | hit_i;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_MODE: rd_data_o = mode_q;
            SEL_MASK: rd_data_o = mask_q;
            SEL_PEND: rd_data_o = pend_q;
            default:  rd_data_o = '0;
        endcase
    end

    assign mode_o = mode_q;
    assign mask_o = mask_q;
    assign pend_o = pend_q;

    // R4: mask is zero on the first cycle after reset
    mask_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0));

    // R9: every detected hit is recorded, even against a clear
    hit_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_i != '0) |=> ((pend_q & $past(hit_i)) == $past(hit_i)));

    // R1: a pending bit only rises because its own line produced a hit
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_q & ~$past(pend_q) & ~$past(hit_i)) == '0));

endmodule

// File: rtl/prio_resolve.sv
module prio_resolve
    import pin_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  line_vec_t        pend_i,
    input  line_vec_t        mask_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vector_o
);

    line_vec_t live;
    winner_t   win;

    assign live = pend_i & mask_i;

    // Ascending scan: a higher index overwrites a lower one, so it wins.
    always_comb begin
        win = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (live[i]) begin
                win.valid = 1'b1;
                win.idx   = IDX_W'(i);
            end
        end
    end

    assign irq_o    = win.valid;
    assign vector_o = win.valid ? code_of(win.idx) : ERR_VEC;

    // R5: while the interrupt is raised the vector is a line code
    line_code_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (vector_o[VEC_W-1 -: VEC_W-IDX_W] == VEC_BASE));

    // R6: with no live request the vector is the error code
    err_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (live == '0) |-> (vector_o == ERR_VEC && !irq_o));

    // R3: a masked line can never be the reported winner
    masked_loses_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> mask_i[win.idx]);

endmodule

// File: rtl/ext_pin_irq_ctrl.sv
module ext_pin_irq_ctrl
    import pin_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       pin_i,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr_en,
    input  logic [15:0]       reg_wr_data,
    output logic [15:0]       reg_rd_data,
    output logic              irq_o,
    output logic [5:0]        vector_o
);

    line_vec_t level, hit, mode, mask, pend;

    pin_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_i),
        .sync_o  (level)
    );

    edge_detect #(.W(NUM_LINES)) u_edge (
        .clk         (clk),
        .rst         (rst),
        .level_i     (level),
        .fall_only_i (mode),
        .hit_o       (hit)
    );

    irq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (reg_addr),
        .wr_en_i   (reg_wr_en),
        .wr_data_i (reg_wr_data),
        .hit_i     (hit),
        .mode_o    (mode),
        .mask_o    (mask),
        .pend_o    (pend),
        .rd_data_o (reg_rd_data)
    );

    prio_resolve u_prio (
        .clk      (clk),
        .rst      (rst),
        .pend_i   (pend),
        .mask_i   (mask),
        .irq_o    (irq_o),
        .vector_o (vector_o)
    );

endmodule

// File: tb/ext_pin_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_pin_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] pin_i;
    logic [1:0]  reg_addr;
    logic        reg_wr_en;
    logic [15:0] reg_wr_data;
    logic [15:0] reg_rd_data;
    logic        irq_o;
    logic [5:0]  vector_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ext_pin_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .irq_o(irq_o), .vector_o(vector_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_vec(input logic [15:0] live);
        for (int j = 15; j >= 0; j--)
            if (live[j]) return {2'b11, 4'(15 - j)};
        return 6'b00_0000;
    endfunction

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rd_data;
    endtask

    // Wait n rising edges, then settle on the following falling edge.
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        rst = 1'b1; pin_i = '0; reg_addr = '0; reg_wr_en = 1'b0; reg_wr_data = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R4 reset state, R6 error vector
        peek(2'd0, rd); check("R4 mode", rd, 0);
        peek(2'd1, rd); check("R4 mask", rd, 0);
        peek(2'd2, rd); check("R4 pend", rd, 0);
        check("R4 irq", irq_o, 0);
        check("R6 vector", vector_o, 6'b00_0000);

        // R11 readback, R8 pending write never sets
        reg_wr(2'd0, 16'hA5C3); peek(2'd0, rd); check("R11 mode", rd, 16'hA5C3);
        reg_wr(2'd1, 16'h5A3C); peek(2'd1, rd); check("R11 mask", rd, 16'h5A3C);
        peek(2'd3, rd); check("R11 addr3", rd, 0);
        reg_wr(2'd2, 16'hFFFF); peek(2'd2, rd); check("R8 no set", rd, 0);
        reg_wr(2'd1, 16'hFFFF);

        // Per-line sweep over both modes: R1 R2 R5 R7 R8 R10
        for (int i = 0; i < 16; i++) begin
            for (int m = 0; m < 2; m++) begin
                logic [15:0] bitv;
                bitv = 16'(1) << i;
                reg_wr(2'd0, m ? bitv : 16'h0);
                @(negedge clk); pin_i[i] = 1'b1;
                edges(2); peek(2'd2, rd); check("R7 early", rd, 0);
                edges(1); peek(2'd2, rd);
                check(m ? "R2 rise ignored" : "R2 rise", rd, m ? 16'h0 : bitv);
                check("R10 irq", irq_o, m ? 0 : 1);
                check("R5 vector", vector_o, m ? 6'b0 : {2'b11, 4'(15 - i)});
                reg_wr(2'd2, bitv); peek(2'd2, rd); check("R8 clear", rd, 0);
                pin_i[i] = 1'b0;
                edges(3); peek(2'd2, rd); check("R2 fall R1", rd, bitv);
                check("R5 vector fall", vector_o, {2'b11, 4'(15 - i)});
                reg_wr(2'd2, bitv);
                check("R6 after clear", vector_o, 6'b0);
            end
        end

        // Priority and masking sweep: R3 R5 R10 R8
        reg_wr(2'd0, 16'h0);
        for (int p = 0; p < 12; p++) begin
            logic [15:0] pat;
            pat = 16'(p * 16'h3A7 + 1) ^ (16'h8000 >> p);
            @(negedge clk); pin_i = pat;
            edges(3);
            for (int k = 0; k < 8; k++) begin
                logic [15:0] mk;
                mk = (16'hFFFF >> (2 * k)) ^ 16'(k * 16'h0F0F);
                reg_wr(2'd1, mk);
                peek(2'd2, rd); check("R3 pend kept", rd, pat);
                check("R5 prio", vector_o, exp_vec(pat & mk));
                check("R10 irq", irq_o, (pat & mk) != 0);
            end
            reg_wr(2'd1, 16'h0);
            check("R3 masked irq", irq_o, 0);
            check("R3 masked vec", vector_o, 6'b0);
            reg_wr(2'd2, 16'h00FF); peek(2'd2, rd); check("R8 partial", rd, pat & 16'hFF00);
            pin_i = '0; edges(3);
            reg_wr(2'd2, 16'hFFFF);
            reg_wr(2'd1, 16'hFFFF);
        end

        // R9 set beats clear in the same cycle
        @(negedge clk); pin_i[3] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_addr = 2'd2; reg_wr_data = 16'h0008; reg_wr_en = 1'b1;
        @(negedge clk); reg_wr_en = 1'b0;
        peek(2'd2, rd); check("R9 set wins", rd, 16'h0008);
        check("R9 vector", vector_o, 6'b11_1100);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule